// File: doc/BRIEF.md
# Block Cipher Accelerator Register Front End

This block is the register-level front end of a DES / Triple-DES accelerator. A host CPU or a DMA engine reaches it through a simple 32-bit register bus. The host loads up to six key words, a two-word chaining vector and a mode word. It then programs a byte count. After that, the block runs one 64-bit block at a time. It raises an input-ready flag and waits for the host to write two data words. It hands the block to an external cipher core over a valid/ready port and collects the core's single-cycle response. It then raises an output-ready flag until the host has read both result words.

In CBC mode the front end applies the chaining XOR itself. It XORs the plaintext before the core when encrypting, and it XORs the core output after the core when decrypting. It keeps the chaining register equal to the last ciphertext block. The remaining byte count drops by one block each time a result has been fully read. The sequence stops once that count is exhausted. The block drives a level interrupt from two write-one-to-clear status bits (data-in and data-out). It also drives two DMA request lines, each gated by its own enable bit.

The rounds of the cipher are not part of this block. Software must write the key, the chaining vector and the mode before it writes the length, and it must rewrite the key for every request.

Top module: `cipherRegFront`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero: key, chaining vector, control, length, data, DMA mask, interrupt status and interrupt enable. The `irq`, `dmaInReq`, `dmaOutReq` and `coreReqValid` outputs are low.
- R2: Logical key word n (0..5) is stored at byte offset 0x14 − 4·(n XOR 1), so words 0..5 sit at 0x10, 0x14, 0x08, 0x0C, 0x00, 0x04. Each key word reads back at its offset. `coreKey` presents word 0 in its top 32 bits and word 5 in its bottom 32 bits.
- R3: In the control word at 0x20, bit 4 selects CBC, bit 3 selects Triple-DES and bit 2 selects encrypt (1) or decrypt (0); these three bits are read/write. Bit 1 is the read-only input-ready flag and bit 0 is the read-only output-ready flag. Writes to bits 1 and 0 have no effect, and every other bit reads zero.
- R4: A nonzero write to the length register at 0x24 while the sequencer is idle loads the length, raises input-ready and sets status bit 1. A write to the length register while a request is in progress is ignored.
- R5: A write to 0x2C while input-ready is high launches one core request. The request block is {word last written to 0x28, word written to 0x2C}, with 0x28 as the upper half. `coreReqValid` and `coreReqData` hold steady until `coreReqReady`. A write to 0x2C outside the input wait launches nothing.
- R6: The chaining vector is written and read at 0x18 (upper half) and 0x1C (lower half). In CBC encrypt the core input is block XOR chain, and the chain then takes the core output. In CBC decrypt the result is core output XOR chain, and the chain then takes the input block. In ECB no XOR is applied and the chain is left unchanged.
- R7: A `coreRspValid` pulse raises output-ready and sets status bit 2. The result is then readable as an upper word at 0x28 and a lower word at 0x2C.
- R8: A read of 0x2C while output-ready is high completes the block and lowers the remaining length by 8, with a floor of zero. If bytes remain, input-ready and status bit 1 rise again. If none remain, the sequencer goes idle and no further data-in request is raised.
- R9: Interrupt status at 0x3C (bit 1 data-in, bit 2 data-out) is cleared by writing 1 to a bit. `irq` is high exactly when some status bit is set and its enable bit at 0x40 (same bit positions) is set.
- R10: In the DMA mask register at 0x34, bit 5 gates `dmaInReq` (input-ready) and bit 6 gates `dmaOutReq` (output-ready).
- R11: The revision register at 0x30 reads the major version in bits 10:8 and the minor version in bits 5:0 (defaults 2 and 5, reading 0x205). Reads of unmapped offsets such as 0x44 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Register write strobe |
| busWrData | input | 32 | Register write data |
| busRdEn | input | 1 | Register read strobe (reads of 0x2C consume a result) |
| busRdData | output | 32 | Read data for busAddr, combinational |
| coreReqValid | output | 1 | Block offered to the cipher core |
| coreReqReady | input | 1 | Cipher core accepts the block |
| coreReqData | output | 64 | Block for the core, already chained in CBC encrypt |
| coreReqEncrypt | output | 1 | Direction for the core, 1 = encrypt |
| coreReqTriple | output | 1 | Triple-DES select for the core |
| coreKey | output | 192 | Key words 0..5, word 0 in the top bits |
| coreRspValid | input | 1 | One-cycle result strobe from the core |
| coreRspData | input | 64 | Core result |
| irq | output | 1 | Level interrupt |
| dmaInReq | output | 1 | DMA request for input data |
| dmaOutReq | output | 1 | DMA request for output data |

## Verification
The bench checks the swapped key map by writing each key word at its offset and comparing `coreKey`. A design that did not swap the pairs would send the halves of each key in the wrong order. The bench checks the countdown on a two-block request. A design that decremented on the wrong event, or that failed to stop at zero, would raise a third data-in request or would leave the length at 8. The bench runs CBC encrypt followed by CBC decrypt of the same ciphertext. A chaining register that took the wrong block on decrypt would corrupt the second plaintext. The bench also checks that the request data holds while the core stalls, that length writes during a request are ignored, and that a write to 0x2C while idle does not launch the core.

// File: rtl/cipherRegPkg.sv
package cipherRegPkg;

  localparam int OFS_IV_HI  = 'h18;
  localparam int OFS_IV_LO  = 'h1C;
  localparam int OFS_CTRL   = 'h20;
  localparam int OFS_LEN    = 'h24;
  localparam int OFS_DAT_HI = 'h28;
  localparam int OFS_DAT_LO = 'h2C;
  localparam int OFS_REV    = 'h30;
  localparam int OFS_DMA    = 'h34;
  localparam int OFS_IST    = 'h3C;
  localparam int OFS_IEN    = 'h40;

  localparam int CB_CBC = 4;
  localparam int CB_TRI = 3;
  localparam int CB_ENC = 2;
  localparam int CB_INR = 1;
  localparam int CB_OUTR = 0;
  localparam int IB_IN  = 1;
  localparam int IB_OUT = 2;
  localparam int DB_IN  = 5;
  localparam int DB_OUT = 6;

  // Key word pairs are stored swapped, counting down from 0x14.
  function automatic int keyOffset(input int n);
    return 'h14 - 4 * (n ^ 1);
  endfunction

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_IN, SEQ_REQ, SEQ_BUSY, SEQ_OUT
  } seqState_t;

  typedef struct packed {
    logic launch;   // block complete, hand to core
    logic armIn;    // raise data-in status
    logic takeRsp;  // capture core result
    logic consume;  // host finished reading the result
  } seqStrobe_t;

endpackage

// File: rtl/cipherRegSeq.sv
module cipherRegSeq
  import cipherRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrLaunchHit,
  input  logic       rdTailHit,
  input  logic       lenStart,
  input  logic       lenLast,
  input  logic       coreReqReady,
  input  logic       coreRspValid,
  output logic       isIdle,
  output logic       inReady,
  output logic       outReady,
  output logic       coreReqValid,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_comb begin
    strobe          = '0;
    stateNext       = state;
    strobe.launch   = (state == SEQ_IN) && wrLaunchHit;
    strobe.takeRsp  = (state == SEQ_BUSY) && coreRspValid;
    strobe.consume  = (state == SEQ_OUT) && rdTailHit;
    strobe.armIn    = ((state == SEQ_IDLE) && lenStart) ||
                      (strobe.consume && !lenLast);
    unique case (state)
      SEQ_IDLE: if (lenStart)       stateNext = SEQ_IN;
      SEQ_IN:   if (wrLaunchHit)    stateNext = SEQ_REQ;
      SEQ_REQ:  if (coreReqReady)   stateNext = SEQ_BUSY;
      SEQ_BUSY: if (coreRspValid)   stateNext = SEQ_OUT;
      SEQ_OUT:  if (rdTailHit)      stateNext = lenLast ? SEQ_IDLE : SEQ_IN;
      default:                      stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign isIdle       = (state == SEQ_IDLE);
  assign inReady      = (state == SEQ_IN);
  assign outReady     = (state == SEQ_OUT);
  assign coreReqValid = (state == SEQ_REQ);

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReqValid && !coreReqReady |=> coreReqValid);

  // R7
  rsp_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeRsp |=> outReady && !inReady);

  // R8
  last_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.consume && lenLast |=> !inReady && !outReady && !coreReqValid);

endmodule

// File: rtl/cipherRegFile.sv
module cipherRegFile
  import cipherRegPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DW        = 32,
  parameter int KEY_WORDS = 6,
  parameter int LEN_W     = 32,
  parameter logic [2:0] REV_MAJOR = 3'd2,
  parameter logic [5:0] REV_MINOR = 6'd5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [DW-1:0]           busWrData,
  input  logic                    busRdEn,
  output logic [DW-1:0]           busRdData,
  input  seqStrobe_t              strobe,
  input  logic                    isIdle,
  input  logic                    inReady,
  input  logic                    outReady,
  input  logic                    coreReqValid,
  input  logic                    coreReqReady,
  output logic                    wrLaunchHit,
  output logic                    rdTailHit,
  output logic                    lenStart,
  output logic                    lenLast,
  output logic [2*DW-1:0]         coreReqData,
  output logic                    coreReqEncrypt,
  output logic                    coreReqTriple,
  output logic [KEY_WORDS*DW-1:0] coreKey,
  input  logic [2*DW-1:0]         coreRspData,
  output logic                    irq,
  output logic                    dmaInReq,
  output logic                    dmaOutReq
);

  localparam int BLK_W     = 2 * DW;
  localparam int BLK_BYTES = BLK_W / 8;

  logic [DW-1:0]    keyWord [KEY_WORDS];
  logic [BLK_W-1:0] chainReg, dataOut, rawBlock, reqBlock;
  logic [DW-1:0]    dataHi;
  logic [LEN_W-1:0] lenReg;
  logic modeCbc, modeTri, modeEnc;
  logic dmaEnIn, dmaEnOut, stIn, stOut, ieIn, ieOut;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic wrCtrl, wrLen, wrIst;
  assign wrCtrl      = busWrEn && hit(busAddr, OFS_CTRL);
  assign wrLen       = busWrEn && hit(busAddr, OFS_LEN);
  assign wrIst       = busWrEn && hit(busAddr, OFS_IST);
  assign wrLaunchHit = busWrEn && hit(busAddr, OFS_DAT_LO);
  assign rdTailHit   = busRdEn && hit(busAddr, OFS_DAT_LO);
  assign lenStart    = wrLen && isIdle && (busWrData[LEN_W-1:0] != '0);
  assign lenLast     = lenReg <= LEN_W'(BLK_BYTES);

  // Key storage with the pair-swapped address map.
  for (genvar g = 0; g < KEY_WORDS; g++) begin : gKey
    localparam int KOFS = keyOffset(g);
    always_ff @(posedge clk) begin
      if (!rstN)                                      keyWord[g] <= '0;
      else if (busWrEn && busAddr == ADDR_W'(KOFS))   keyWord[g] <= busWrData;
    end
    assign coreKey[(KEY_WORDS-1-g)*DW +: DW] = keyWord[g];
  end

  // Control, length, data, chaining.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      {modeCbc, modeTri, modeEnc} <= '0;
      {dmaEnIn, dmaEnOut, ieIn, ieOut} <= '0;
      lenReg   <= '0;
      dataHi   <= '0;
      chainReg <= '0;
      dataOut  <= '0;
      rawBlock <= '0;
      reqBlock <= '0;
    end else begin
      if (wrCtrl) begin
        modeCbc <= busWrData[CB_CBC];
        modeTri <= busWrData[CB_TRI];
        modeEnc <= busWrData[CB_ENC];
      end
      if (busWrEn && hit(busAddr, OFS_DMA)) begin
        dmaEnIn  <= busWrData[DB_IN];
        dmaEnOut <= busWrData[DB_OUT];
      end
      if (busWrEn && hit(busAddr, OFS_IEN)) begin
        ieIn  <= busWrData[IB_IN];
        ieOut <= busWrData[IB_OUT];
      end
      if (wrLen && isIdle) lenReg <= busWrData[LEN_W-1:0];
      else if (strobe.consume)
        lenReg <= lenLast ? '0 : lenReg - LEN_W'(BLK_BYTES);
      if (busWrEn && hit(busAddr, OFS_DAT_HI)) dataHi <= busWrData;
      if (busWrEn && hit(busAddr, OFS_IV_HI))  chainReg[BLK_W-1:DW] <= busWrData;
      if (busWrEn && hit(busAddr, OFS_IV_LO))  chainReg[DW-1:0]     <= busWrData;
      if (strobe.launch) begin
        rawBlock <= {dataHi, busWrData};
        reqBlock <= (modeCbc && modeEnc) ? ({dataHi, busWrData} ^ chainReg)
                                         : {dataHi, busWrData};
      end
      if (strobe.takeRsp) begin
        dataOut <= (modeCbc && !modeEnc) ? (coreRspData ^ chainReg) : coreRspData;
        if (modeCbc) chainReg <= modeEnc ? coreRspData : rawBlock;
      end
    end
  end

  // Interrupt status: hardware set wins over a same-cycle clear.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stIn  <= 1'b0;
      stOut <= 1'b0;
    end else begin
      if (strobe.armIn)                      stIn <= 1'b1;
      else if (wrIst && busWrData[IB_IN])    stIn <= 1'b0;
      if (strobe.takeRsp)                    stOut <= 1'b1;
      else if (wrIst && busWrData[IB_OUT])   stOut <= 1'b0;
    end
  end

  assign irq            = (stIn && ieIn) || (stOut && ieOut);
  assign dmaInReq       = dmaEnIn && inReady;
  assign dmaOutReq      = dmaEnOut && outReady;
  assign coreReqData    = reqBlock;
  assign coreReqEncrypt = modeEnc;
  assign coreReqTriple  = modeTri;

  always_comb begin
    busRdData = '0;
    for (int k = 0; k < KEY_WORDS; k++)
      if (busAddr == ADDR_W'(keyOffset(k))) busRdData = keyWord[k];
    if (hit(busAddr, OFS_IV_HI))  busRdData = chainReg[BLK_W-1:DW];
    if (hit(busAddr, OFS_IV_LO))  busRdData = chainReg[DW-1:0];
    if (hit(busAddr, OFS_CTRL)) begin
      busRdData[CB_CBC]  = modeCbc;
      busRdData[CB_TRI]  = modeTri;
      busRdData[CB_ENC]  = modeEnc;
      busRdData[CB_INR]  = inReady;
      busRdData[CB_OUTR] = outReady;
    end
    if (hit(busAddr, OFS_LEN))    busRdData = DW'(lenReg);
    if (hit(busAddr, OFS_DAT_HI)) busRdData = dataOut[BLK_W-1:DW];
    if (hit(busAddr, OFS_DAT_LO)) busRdData = dataOut[DW-1:0];
    if (hit(busAddr, OFS_REV))    busRdData = DW'({REV_MAJOR, 2'b00, REV_MINOR});
    if (hit(busAddr, OFS_DMA)) begin
      busRdData[DB_IN]  = dmaEnIn;
      busRdData[DB_OUT] = dmaEnOut;
    end
    if (hit(busAddr, OFS_IST)) begin
      busRdData[IB_IN]  = stIn;
      busRdData[IB_OUT] = stOut;
    end
    if (hit(busAddr, OFS_IEN)) begin
      busRdData[IB_IN]  = ieIn;
      busRdData[IB_OUT] = ieOut;
    end
  end

  // R5
  req_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreReqValid && !coreReqReady |=> $stable(coreReqData));

  // R4
  len_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrLen && !isIdle && !strobe.consume |=> $stable(lenReg));

  // R8
  len_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.consume && !lenLast |=> lenReg == $past(lenReg) - LEN_W'(BLK_BYTES));

  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrIst && busWrData[IB_OUT] && !strobe.takeRsp |=> !stOut);

endmodule

// File: rtl/cipherRegFront.sv
module cipherRegFront
  import cipherRegPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DW        = 32,
  parameter int KEY_WORDS = 6,
  parameter int LEN_W     = 32,
  parameter logic [2:0] REV_MAJOR = 3'd2,
  parameter logic [5:0] REV_MINOR = 6'd5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       busAddr,
  input  logic                    busWrEn,
  input  logic [DW-1:0]           busWrData,
  input  logic                    busRdEn,
  output logic [DW-1:0]           busRdData,
  output logic                    coreReqValid,
  input  logic                    coreReqReady,
  output logic [2*DW-1:0]         coreReqData,
  output logic                    coreReqEncrypt,
  output logic                    coreReqTriple,
  output logic [KEY_WORDS*DW-1:0] coreKey,
  input  logic                    coreRspValid,
  input  logic [2*DW-1:0]         coreRspData,
  output logic                    irq,
  output logic                    dmaInReq,
  output logic                    dmaOutReq
);

  seqStrobe_t strobe;
  logic isIdle, inReady, outReady;
  logic wrLaunchHit, rdTailHit, lenStart, lenLast;

  cipherRegSeq uSeq (
    .clk(clk), .rstN(rstN),
    .wrLaunchHit(wrLaunchHit), .rdTailHit(rdTailHit),
    .lenStart(lenStart), .lenLast(lenLast),
    .coreReqReady(coreReqReady), .coreRspValid(coreRspValid),
    .isIdle(isIdle), .inReady(inReady), .outReady(outReady),
    .coreReqValid(coreReqValid), .strobe(strobe)
  );

  cipherRegFile #(
    .ADDR_W(ADDR_W), .DW(DW), .KEY_WORDS(KEY_WORDS), .LEN_W(LEN_W),
    .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
  ) uFile (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .strobe(strobe), .isIdle(isIdle), .inReady(inReady), .outReady(outReady),
    .coreReqValid(coreReqValid), .coreReqReady(coreReqReady),
    .wrLaunchHit(wrLaunchHit), .rdTailHit(rdTailHit),
    .lenStart(lenStart), .lenLast(lenLast),
    .coreReqData(coreReqData), .coreReqEncrypt(coreReqEncrypt),
    .coreReqTriple(coreReqTriple), .coreKey(coreKey),
    .coreRspData(coreRspData),
    .irq(irq), .dmaInReq(dmaInReq), .dmaOutReq(dmaOutReq)
  );

endmodule

// File: tb/cipherRegFront_test.sv
module cipherRegFront_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [7:0]   busAddr = '0;
  logic         busWrEn = 1'b0;
  logic [31:0]  busWrData = '0;
  logic         busRdEn = 1'b0;
  logic [31:0]  busRdData;
  logic         coreReqValid, coreReqEncrypt, coreReqTriple;
  logic         coreReqReady = 1'b1;
  logic [63:0]  coreReqData;
  logic [191:0] coreKey;
  logic         coreRspValid;
  logic [63:0]  coreRspData;
  logic         irq, dmaInReq, dmaOutReq;

  int checks = 0;
  int fails = 0;
  int reqCount = 0;
  logic [31:0] keyVal [6];

  always #4 clk = ~clk;

  cipherRegFront uut (
    .clk(clk), .rstN(rstN),
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdEn(busRdEn), .busRdData(busRdData),
    .coreReqValid(coreReqValid), .coreReqReady(coreReqReady),
    .coreReqData(coreReqData), .coreReqEncrypt(coreReqEncrypt),
    .coreReqTriple(coreReqTriple), .coreKey(coreKey),
    .coreRspValid(coreRspValid), .coreRspData(coreRspData),
    .irq(irq), .dmaInReq(dmaInReq), .dmaOutReq(dmaOutReq)
  );

  // Invertible stand-in transform for the cipher rounds.
  function automatic logic [63:0] xf(input logic [63:0] x, input logic [191:0] k,
                                     input logic tri3, input logic enc);
    logic [63:0] k64, y;
    k64 = tri3 ? (k[191:128] ^ k[127:64] ^ k[63:0]) : k[191:128];
    if (enc) xf = {x[31:0], x[63:32]} ^ k64;
    else begin
      y  = x ^ k64;
      xf = {y[31:0], y[63:32]};
    end
  endfunction

  // Stand-in core: fixed latency of three cycles.
  logic [63:0] coreHold;
  logic        corePend;
  int          coreCnt;
  logic        rspV;
  always @(posedge clk) begin
    if (!rstN) begin
      corePend <= 1'b0; rspV <= 1'b0; coreCnt <= 0; coreHold <= '0;
    end else begin
      rspV <= 1'b0;
      if (coreReqValid && coreReqReady) begin
        corePend <= 1'b1; coreCnt <= 3;
        coreHold <= xf(coreReqData, coreKey, coreReqTriple, coreReqEncrypt);
        reqCount <= reqCount + 1;
      end else if (corePend) begin
        if (coreCnt == 1) begin rspV <= 1'b1; corePend <= 1'b0; end
        coreCnt <= coreCnt - 1;
      end
    end
  end
  assign coreRspValid = rspV;
  assign coreRspData  = coreHold;

  task automatic chk(input string tag, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk); busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRdEn = 1'b1;
    #2 d = busRdData;
    @(negedge clk); busRdEn = 1'b0;
  endtask

  function automatic logic [191:0] keyCat();
    return {keyVal[0], keyVal[1], keyVal[2], keyVal[3], keyVal[4], keyVal[5]};
  endfunction

  task automatic loadKeys(input logic [31:0] seed);
    for (int n = 0; n < 6; n++) begin
      keyVal[n] = seed ^ (32'h1111_0000 * (n + 1)) ^ n;
      busWrite(8'(8'h14 - 4 * (n ^ 1)), keyVal[n]);
    end
  endtask

  task automatic waitOut();
    logic [31:0] r;
    bit seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      busRead(8'h20, r);
      seen = r[0];
    end
    chk("R7 output-ready seen", seen, 1);
  endtask

  task automatic runBlock(input logic [63:0] blk, output logic [63:0] res);
    logic [31:0] hi, lo;
    busWrite(8'h28, blk[63:32]);
    busWrite(8'h2C, blk[31:0]);
    waitOut();
    busRead(8'h28, hi);
    busRead(8'h2C, lo);
    res = {hi, lo};
  endtask

  task automatic testReset();
    logic [31:0] r;
    busRead(8'h20, r); chk("R1 ctrl after reset", r, 0);
    busRead(8'h24, r); chk("R1 length after reset", r, 0);
    busRead(8'h3C, r); chk("R1 status after reset", r, 0);
    busRead(8'h10, r); chk("R1 key after reset", r, 0);
    chk("R1 outputs after reset", {irq, dmaInReq, dmaOutReq, coreReqValid}, 0);
    busRead(8'h30, r); chk("R11 revision", r, 32'h205);
    busRead(8'h44, r); chk("R11 unmapped read", r, 0);
  endtask

  task automatic testIdleLaunch();
    busWrite(8'h2C, 32'hDEAD_BEEF);
    repeat (4) @(negedge clk);
    chk("R5 idle 0x2C write launches nothing", {coreReqValid, 32'(reqCount)}, 0);
  endtask

  task automatic testKeyMap();
    logic [31:0] r;
    loadKeys(32'hA5A5_0F0F);
    chk("R2 coreKey order", coreKey, keyCat());
    busRead(8'h08, r); chk("R2 key word 2 at 0x08", r, keyVal[2]);
    busRead(8'h04, r); chk("R2 key word 5 at 0x04", r, keyVal[5]);
  endtask

  task automatic testCtrlBits();
    logic [31:0] r;
    busWrite(8'h20, 32'hFFFF_FFFF);
    busRead(8'h20, r); chk("R3 ctrl read-only flags", r, 32'h1C);
    busWrite(8'h20, 32'h0);
  endtask

  task automatic testEcbTwoBlocks();
    logic [31:0] r;
    logic [63:0] res;
    busWrite(8'h20, 32'h04);
    busWrite(8'h34, 32'h60);
    busWrite(8'h40, 32'h06);
    busWrite(8'h24, 32'd16);
    busRead(8'h20, r); chk("R4 input-ready after length", r, 32'h06);
    busRead(8'h3C, r); chk("R4 data-in status", r, 32'h2);
    chk("R9 R10 irq and dma-in", {irq, dmaInReq, dmaOutReq}, 3'b110);
    busWrite(8'h3C, 32'h2);
    busRead(8'h3C, r); chk("R9 w1c clears data-in", {r, irq}, 0);
    busWrite(8'h28, 32'h0123_4567);
    busWrite(8'h2C, 32'h89AB_CDEF);
    waitOut();
    busRead(8'h3C, r); chk("R7 data-out status", r, 32'h4);
    chk("R10 dma-out request", {irq, dmaInReq, dmaOutReq}, 3'b101);
    busRead(8'h28, r); chk("R7 result upper", r, xf(64'h0123_4567_89AB_CDEF, keyCat(), 0, 1) >> 32);
    busRead(8'h2C, r); chk("R7 result lower", r, xf(64'h0123_4567_89AB_CDEF, keyCat(), 0, 1) & 64'hFFFF_FFFF);
    busRead(8'h24, r); chk("R8 length after first block", r, 8);
    busRead(8'h20, r); chk("R8 input-ready again", r, 32'h06);
    busRead(8'h3C, r); chk("R8 data-in re-raised", r, 32'h6);
    busWrite(8'h3C, 32'h6);
    runBlock(64'hFEDC_BA98_7654_3210, res);
    chk("R7 second block", res, xf(64'hFEDC_BA98_7654_3210, keyCat(), 0, 1));
    busRead(8'h24, r); chk("R8 length exhausted", r, 0);
    busRead(8'h20, r); chk("R8 idle after last block", r, 32'h04);
    busRead(8'h3C, r); chk("R8 no data-in after last block", r, 32'h4);
    busWrite(8'h3C, 32'h4);
    chk("R9 irq low after clear", irq, 0);
    busWrite(8'h34, 32'h0);
    busWrite(8'h40, 32'h0);
  endtask

  task automatic testCbc();
    logic [31:0] r, r2;
    logic [63:0] iv, p1, p2, c1, c2, res;
    iv = 64'h1357_9BDF_0246_8ACE;
    p1 = 64'h1111_2222_3333_4444;
    p2 = 64'h5555_6666_7777_8888;
    loadKeys(32'h3C3C_1234);
    c1 = xf(p1 ^ iv, keyCat(), 0, 1);
    c2 = xf(p2 ^ c1, keyCat(), 0, 1);
    busWrite(8'h20, 32'h14);
    busWrite(8'h18, iv[63:32]);
    busWrite(8'h1C, iv[31:0]);
    busWrite(8'h24, 32'd16);
    runBlock(p1, res); chk("R6 CBC encrypt block 1", res, c1);
    runBlock(p2, res); chk("R6 CBC encrypt block 2", res, c2);
    busRead(8'h18, r); busRead(8'h1C, r2);
    chk("R6 chain holds last ciphertext", {r, r2}, c2);
    loadKeys(32'h3C3C_1234);
    busWrite(8'h20, 32'h10);
    busWrite(8'h18, iv[63:32]);
    busWrite(8'h1C, iv[31:0]);
    busWrite(8'h24, 32'd16);
    runBlock(c1, res); chk("R6 CBC decrypt block 1", res, p1);
    runBlock(c2, res); chk("R6 CBC decrypt block 2", res, p2);
  endtask

  task automatic testTripleHold();
    logic [31:0] r;
    logic [63:0] held, res, x;
    x = 64'hCAFE_F00D_0BAD_BEEF;
    loadKeys(32'h7777_ABCD);
    busWrite(8'h20, 32'h08);
    busWrite(8'h24, 32'd8);
    busWrite(8'h24, 32'd64);
    busRead(8'h24, r); chk("R4 length write ignored while busy", r, 8);
    coreReqReady = 1'b0;
    busWrite(8'h28, x[63:32]);
    busWrite(8'h2C, x[31:0]);
    chk("R5 request offered", {coreReqValid, coreReqData}, {1'b1, x});
    held = coreReqData;
    repeat (3) @(negedge clk);
    chk("R5 request held during stall", {coreReqValid, coreReqData}, {1'b1, held});
    coreReqReady = 1'b1;
    waitOut();
    busRead(8'h28, r); res[63:32] = r;
    busRead(8'h2C, r); res[31:0] = r;
    chk("R3 triple decrypt result", res, xf(x, keyCat(), 1, 0));
  endtask

  initial begin
    #(8 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIdleLaunch();
    testKeyMap();
    testCtrlBits();
    testEcbTwoBlocks();
    testCbc();
    testTripleHold();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule